// File: doc/BRIEF.md
# Multichannel DAC command decoder

This block takes 16-bit command words from a three-wire serial link and carries them out. The link has a serial clock, a data input and a load strobe. Each word can set one of twelve 8-bit DAC output registers directly, or copy a stored byte into one channel or into all channels. It can also write a byte into a small non-volatile store of four banks by twelve channels, or send a stored byte back on a serial data-out line. A write-enable latch guards every store write. Two reserved channel codes set and clear this latch.

Word layout, from the most significant bit: bank select (2 bits, bits 15..14), command bit C (bit 13), command bit W (bit 12), channel code (bits 11..8), data byte (bits 7..0). Channel codes 1 to 12 address DAC registers 1 to 12. The serial lines are sampled by the system clock. They must be synchronous to it, and each level must be held for at least two system clock cycles. The store keeps its contents through reset. After every reset, the block copies bank 0 into all twelve DAC registers.

Top module: `dac_cmd_decoder`

## Requirements
- R1: A data bit is shifted in, MSB first, on each rising edge of sclk while ld is low. A falling edge of ld clears the bit count. A rising edge of ld executes the word only if exactly 16 bits were shifted since the last falling edge of ld. Frames of 15 or 17 bits have no effect.
- R2: When C=0 and W=0 and the channel is 1..12, the data byte goes into that channel's DAC register. The bank bits are ignored.
- R3: When C=1 and W=0 and the channel is 1..12, the stored byte at (bank, channel) goes into that channel's DAC register. The data byte is ignored.
- R4: When C=1, W=0 and the channel is 0, all twelve DAC registers are loaded in the same cycle from the twelve stored bytes of the selected bank.
- R5: When C=1 and W=1, channel 0 sets the write-enable latch and channel 15 clears it.
- R6: When C=0 and W=1 and the channel is 1..12, the data byte is written to the store at (bank, channel), but only while the write-enable latch is set. Otherwise the word has no effect. A store write never changes a DAC register.
- R7: When C=1 and W=1 and the channel is 1..12, sdo presents bit 7 of the stored byte at (bank, channel). Each later sclk falling edge moves sdo to the next lower bit. After the eighth falling edge sdo returns low, and sdo is low whenever no readback is in progress.
- R8: After reset, all twelve DAC registers are loaded from bank 0 and the write-enable latch is cleared. Store contents survive reset.
- R9: Channel codes 0, 13, 14 and 15 leave all state unchanged for direct load, single recall and store write. Codes 13 and 14 do the same for readback.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| sclk | input | 1 | Serial clock |
| sdi | input | 1 | Serial data in, MSB first |
| ld | input | 1 | Load strobe; rising edge executes the word |
| dacOut | output | 96 | Twelve DAC registers; channel n occupies bits 8n-1..8n-8 |
| sdo | output | 1 | Serial readback data |

## Verification
The bench builds the block with its default sizes: twelve channels, four banks and 8-bit data. This lets every channel be written in one bank and recalled together with one broadcast word. All four bank codes appear, so a byte stored in one bank can be told apart from a byte in another bank at the same channel. Bank 0 is filled before a second reset, which makes the automatic recall and the latch clearing visible at the DAC outputs.

// File: rtl/dacdec_pkg.sv
package dacdec_pkg;
  localparam int WORD_W   = 16;
  localparam int CH_W     = 4;
  localparam int BANK_W   = 2;
  localparam int DATA_W   = 8;
  localparam int NUM_CH   = 12;
  localparam int NUM_BANK = 1 << BANK_W;
  localparam int CNT_W    = $clog2(WORD_W + 2);
  localparam int IDX_W    = $clog2(NUM_BANK * NUM_CH);
  localparam int LEFT_W   = $clog2(DATA_W + 1);

  typedef struct packed {
    logic                loadDirect;
    logic                recallOne;
    logic                recallAll;
    logic                storeWrite;
    logic                setWel;
    logic                clrWel;
    logic                readOut;
    logic                autoRecall;
    logic                sclkFall;
    logic [BANK_W-1:0]   bank;
    logic [CH_W-1:0]     chan;
    logic [DATA_W-1:0]   data;
  } strobe_t;
endpackage

// File: rtl/dacdec_ctrl.sv
module dacdec_ctrl
  import dacdec_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    sclk,
  input  logic    sdi,
  input  logic    ld,
  output strobe_t strb
);
  logic              sclkQ, ldQ, bootDone;
  logic [WORD_W-1:0] shiftReg;
  logic [CNT_W-1:0]  bitCnt;
  logic              sclkRise, sclkFallNow, ldRise, ldFall, frameOk, chanValid;
  logic [CH_W-1:0]   chanField;
  strobe_t           nxt;

  assign sclkRise    = sclk & ~sclkQ;
  assign sclkFallNow = ~sclk & sclkQ;
  assign ldRise      = ld & ~ldQ;
  assign ldFall      = ~ld & ldQ;
  assign frameOk     = ldRise && (bitCnt == CNT_W'(WORD_W));
  assign chanField   = shiftReg[DATA_W +: CH_W];
  assign chanValid   = (chanField != '0) && (chanField <= CH_W'(NUM_CH));

  always_comb begin
    nxt          = '0;
    nxt.bank     = shiftReg[WORD_W-1 -: BANK_W];
    nxt.chan     = chanField;
    nxt.data     = shiftReg[DATA_W-1:0];
    nxt.sclkFall = sclkFallNow;
    if (!bootDone) begin
      nxt.autoRecall = 1'b1;
    end else if (frameOk) begin
      case (shiftReg[WORD_W-BANK_W-1 -: 2])
        2'b00: nxt.loadDirect = chanValid;
        2'b10: begin
          if (chanField == '0) nxt.recallAll = 1'b1;
          else                 nxt.recallOne = chanValid;
        end
        2'b01: nxt.storeWrite = chanValid;
        default: begin
          if (chanField == '0)      nxt.setWel  = 1'b1;
          else if (chanField == '1) nxt.clrWel  = 1'b1;
          else                      nxt.readOut = chanValid;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclkQ    <= 1'b0;
      ldQ      <= 1'b0;
      bootDone <= 1'b0;
      shiftReg <= '0;
      bitCnt   <= '0;
      strb     <= '0;
    end else begin
      sclkQ    <= sclk;
      ldQ      <= ld;
      bootDone <= 1'b1;
      strb     <= nxt;
      if (ldFall) begin
        bitCnt <= '0;
      end else if (sclkRise && !ld) begin
        shiftReg <= {shiftReg[WORD_W-2:0], sdi};
        if (bitCnt != CNT_W'(WORD_W + 1)) bitCnt <= bitCnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/dacdec_path.sv
module dacdec_path
  import dacdec_pkg::*;
(
  input  logic                     clk,
  input  logic                     rstN,
  input  strobe_t                  strb,
  output logic [NUM_CH*DATA_W-1:0] dacOut,
  output logic                     sdo
);
  logic [DATA_W-1:0] store [NUM_BANK*NUM_CH];
  logic [DATA_W-1:0] dacReg [NUM_CH];
  logic              welQ;
  logic [DATA_W-1:0] rbShift;
  logic [LEFT_W-1:0] rbLeft;
  logic [CH_W-1:0]   chanIdx;
  logic [IDX_W-1:0]  selIdx;
  logic [BANK_W-1:0] recallBank;

  assign chanIdx    = strb.chan - 1'b1;
  assign selIdx     = IDX_W'(strb.bank) * IDX_W'(NUM_CH) + IDX_W'(chanIdx);
  assign recallBank = strb.autoRecall ? '0 : strb.bank;
  assign sdo        = (rbLeft != '0) & rbShift[DATA_W-1];

  always_ff @(posedge clk) begin
    if (strb.storeWrite && welQ) store[selIdx] <= strb.data;
  end

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    logic [IDX_W-1:0] allIdx;
    assign allIdx = IDX_W'(recallBank) * IDX_W'(NUM_CH) + IDX_W'(i);
    assign dacOut[i*DATA_W +: DATA_W] = dacReg[i];

    always_ff @(posedge clk) begin
      if (!rstN) begin
        dacReg[i] <= '0;
      end else if (strb.autoRecall || strb.recallAll) begin
        dacReg[i] <= store[allIdx];
      end else if (strb.loadDirect && chanIdx == CH_W'(i)) begin
        dacReg[i] <= strb.data;
      end else if (strb.recallOne && chanIdx == CH_W'(i)) begin
        dacReg[i] <= store[selIdx];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      welQ    <= 1'b0;
      rbShift <= '0;
      rbLeft  <= '0;
    end else begin
      if (strb.autoRecall || strb.clrWel) welQ <= 1'b0;
      else if (strb.setWel)               welQ <= 1'b1;
      if (strb.readOut) begin
        rbShift <= store[selIdx];
        rbLeft  <= LEFT_W'(DATA_W);
      end else if (strb.sclkFall && rbLeft != '0) begin
        rbShift <= {rbShift[DATA_W-2:0], 1'b0};
        rbLeft  <= rbLeft - 1'b1;
      end
    end
  end
endmodule

// File: rtl/dac_cmd_decoder.sv
module dac_cmd_decoder
  import dacdec_pkg::*;
(
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     sclk,
  input  logic                     sdi,
  input  logic                     ld,
  output logic [NUM_CH*DATA_W-1:0] dacOut,
  output logic                     sdo
);
  strobe_t strb;

  dacdec_ctrl u_ctrl (
    .clk  (clk),
    .rstN (rstN),
    .sclk (sclk),
    .sdi  (sdi),
    .ld   (ld),
    .strb (strb)
  );

  dacdec_path u_path (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .dacOut (dacOut),
    .sdo    (sdo)
  );
endmodule

// File: rtl/dac_cmd_decoder_chk.sv
module dac_cmd_decoder_chk
  import dacdec_pkg::*;
(
  input logic                     clk,
  input logic                     rstN,
  input strobe_t                  strb,
  input logic [NUM_CH*DATA_W-1:0] dacOut,
  input logic                     sdo
);
  function automatic logic [DATA_W-1:0] chanByte(logic [NUM_CH*DATA_W-1:0] v,
                                                 logic [CH_W-1:0] ch);
    logic [NUM_CH*DATA_W-1:0] sh;
    sh = v >> (DATA_W * (int'(ch) - 1));
    return sh[DATA_W-1:0];
  endfunction

  // R1: at most one command acts per cycle
  p_one_cmd_r1: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.loadDirect, strb.recallOne, strb.recallAll, strb.storeWrite,
              strb.setWel, strb.clrWel, strb.readOut, strb.autoRecall}));

  // R2: a direct load lands its byte on the addressed channel
  p_load_value_r2: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadDirect |=> chanByte(dacOut, $past(strb.chan)) == $past(strb.data));

  // R9: DAC outputs move only on a load or recall strobe
  p_dac_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.loadDirect || strb.recallOne || strb.recallAll || strb.autoRecall)
      |=> $stable(dacOut));

  // R7: readback output changes only on a read command or a serial falling edge
  p_sdo_move_r7: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.readOut || strb.sclkFall) |=> $stable(sdo));

  // R8: the automatic recall is a single pulse
  p_boot_once_r8: assert property (@(posedge clk) disable iff (!rstN)
    strb.autoRecall |=> !strb.autoRecall);
endmodule

bind dac_cmd_decoder dac_cmd_decoder_chk u_chk (
  .clk    (clk),
  .rstN   (rstN),
  .strb   (strb),
  .dacOut (dacOut),
  .sdo    (sdo)
);

// File: tb/sim_dac_cmd_decoder.sv
module sim_dac_cmd_decoder;
  import dacdec_pkg::*;

  logic clk = 1'b0, rstN = 1'b0, sclk = 1'b0, sdi = 1'b0, ld = 1'b0;
  logic [NUM_CH*DATA_W-1:0] dacOut;
  logic sdo;
  int nChk = 0, nBad = 0;

  dac_cmd_decoder u0 (.clk(clk), .rstN(rstN), .sclk(sclk), .sdi(sdi), .ld(ld),
                      .dacOut(dacOut), .sdo(sdo));

  always #10 clk = ~clk;

  typedef struct packed {
    logic [15:0] w;
    logic [3:0]  ch;
    logic [7:0]  exp;
  } vec_t;

  // word = {bank[1:0], C, W, chan[3:0], data[7:0]}
  localparam int NVEC = 13;
  localparam vec_t VEC [NVEC] = '{
    '{16'hC111, 4'd1,  8'h11},  // R2 direct load ch1, bank bits ignored
    '{16'h0CC3, 4'd12, 8'hC3},  // R2 direct load ch12
    '{16'h0444, 4'd4,  8'h44},  // R2 direct load ch4
    '{16'h3000, 4'd4,  8'h44},  // R5 set latch, DAC untouched
    '{16'h945A, 4'd4,  8'h44},  // R6 store write bank2 ch4, DAC untouched
    '{16'hA4FF, 4'd4,  8'h5A},  // R3 recall bank2 ch4, data ignored
    '{16'h5477, 4'd4,  8'h5A},  // R6 store write bank1 ch4
    '{16'h6400, 4'd4,  8'h77},  // R3 recall bank1 ch4
    '{16'h3F00, 4'd4,  8'h77},  // R5 clear latch
    '{16'h9499, 4'd4,  8'h77},  // R6 guarded write, ignored
    '{16'hA400, 4'd4,  8'h5A},  // R6 bank2 ch4 kept old byte
    '{16'h0DEE, 4'd12, 8'hC3},  // R9 channel 13 load ignored
    '{16'h00EE, 4'd1,  8'h11}   // R9 channel 0 load ignored
  };

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(string tag, int act, int exp);
    nChk++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int dacByte(int ch);
    return int'(dacOut[(ch-1)*DATA_W +: DATA_W]);
  endfunction

  function automatic logic [15:0] mk(int bank, int c, int w, int ch, int data);
    return {2'(bank), 1'(c), 1'(w), 4'(ch), 8'(data)};
  endfunction

  task automatic sendBits(logic [31:0] v, int n);
    for (int i = n - 1; i >= 0; i--) begin
      sdi = v[i];
      tick(2);
      sclk = 1'b1;
      tick(2);
      sclk = 1'b0;
    end
    tick(2);
  endtask

  task automatic frame();
    ld = 1'b1;
    tick(4);
    ld = 1'b0;
    tick(2);
  endtask

  task automatic sendWord(logic [15:0] w);
    sendBits({16'h0, w}, 16);
    frame();
  endtask

  task automatic readCheck(int bank, int ch, logic [7:0] exp);
    sendBits({16'h0, mk(bank, 1, 1, ch, 0)}, 16);
    ld = 1'b1;
    tick(4);
    check($sformatf("R7 read ch%0d bit7", ch), int'(sdo), int'(exp[7]));
    for (int k = 6; k >= -1; k--) begin
      sclk = 1'b1;
      tick(2);
      sclk = 1'b0;
      tick(3);
      if (k >= 0) check($sformatf("R7 read ch%0d bit%0d", ch, k), int'(sdo), int'(exp[k]));
      else        check("R7 sdo low after eighth fall", int'(sdo), 0);
    end
    ld = 1'b0;
    tick(2);
  endtask

  task automatic finishRun();
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nBad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nBad++;
    $display("FAIL watchdog expired actual=running expected=done");
    finishRun();
  end

  initial begin
    tick(5);
    rstN = 1'b1;
    tick(4);
    check("R7 sdo low after reset", int'(sdo), 0);

    for (int i = 0; i < NVEC; i++) begin
      sendWord(VEC[i].w);
      check($sformatf("vector %0d word %h ch%0d", i, VEC[i].w, VEC[i].ch),
            dacByte(int'(VEC[i].ch)), int'(VEC[i].exp));
    end

    // fill bank3 and bank0, then broadcast recall of bank3
    sendWord(mk(0, 1, 1, 0, 0));
    for (int ch = 1; ch <= NUM_CH; ch++) begin
      sendWord(mk(3, 0, 1, ch, ch * 17));
      sendWord(mk(0, 0, 1, ch, 8'hA0 + ch));
    end
    sendWord(mk(0, 0, 0, 5, 0));
    check("R2 ch5 cleared before broadcast", dacByte(5), 0);
    sendWord(mk(3, 1, 0, 0, 8'h12));
    for (int ch = 1; ch <= NUM_CH; ch++)
      check($sformatf("R4 broadcast recall ch%0d", ch), dacByte(ch), ch * 17);

    readCheck(3, 7, 8'h77);
    readCheck(3, 10, 8'hAA);

    // R9: read of channel 13 leaves sdo low
    sendBits({16'h0, mk(3, 1, 1, 13, 0)}, 16);
    ld = 1'b1;
    tick(4);
    check("R9 read ch13 sdo", int'(sdo), 0);
    sclk = 1'b1; tick(2); sclk = 1'b0; tick(3);
    check("R9 read ch13 sdo after fall", int'(sdo), 0);
    ld = 1'b0;
    tick(2);

    // R1: framing
    sendBits({16'h0, mk(0, 0, 0, 1, 8'h5F)}, 15);
    frame();
    check("R1 15-bit frame ignored", dacByte(1), 8'h11);
    sendBits({15'h0, 1'b0, mk(0, 0, 0, 1, 8'h5F)}, 17);
    frame();
    check("R1 17-bit frame ignored", dacByte(1), 8'h11);
    sendWord(mk(0, 0, 0, 1, 8'h5F));
    check("R1 16-bit frame executes", dacByte(1), 8'h5F);

    // R8: reset recalls bank0 and clears the latch
    rstN = 1'b0;
    tick(3);
    rstN = 1'b1;
    tick(5);
    for (int ch = 1; ch <= NUM_CH; ch++)
      check($sformatf("R8 boot recall ch%0d", ch), dacByte(ch), 8'hA0 + ch);
    check("R8 sdo low after reset", int'(sdo), 0);
    sendWord(mk(0, 0, 1, 2, 8'h00));
    sendWord(mk(0, 1, 0, 2, 0));
    check("R8 latch cleared by reset", dacByte(2), 8'hA2);

    finishRun();
  end
endmodule